// File: doc/BRIEF.md
# Constant Off-Time Gate Sequencer

This block sequences the switch gate of one channel of an asynchronous buck stage that regulates by constant off-time. Once the channel is allowed to run, the gate is turned on and stays on until the current-sense comparator reports that the sensed level has reached the reference. The gate is then held low for a programmed number of clock cycles, and a new on-period follows. The on-time is therefore set by the load and the comparator, and the off-time by the setting.

For the first part of every on-period the comparator is ignored, so that the current spike at switch turn-on cannot end the on-time early. That blanking window is also brought out for the protection sense logic. A one-cycle sample strobe at a fixed delay after each gate rise tells that logic when to take its over- and under-voltage sample. A maximum on-time limit turns the gate off if the comparator never trips, and a one-cycle flag reports that event. With a 125 MHz clock the default window lengths are 63 cycles of blanking (about 500 ns), a strobe 94 cycles after the rise (about 750 ns) and a 2500-cycle (20 µs) on-time limit. An off-time of 125 cycles gives 1 µs.

Top module: `cot_gate_seq`

## Requirements
- R1: The channel may run when `chip_en` and `supply_ok` are high and `dim_blank` and `prot_off` are low. From the idle state, `gate` goes high at the first clock edge at which the channel may run.
- R2: Let n be the number of clocks since `gate` rose, with n = 0 in the cycle right after the rise. If `sense_hit` is high in a cycle with n >= BLANK_CYC (63), `gate` falls at the next edge. The on-time is then n+1 cycles.
- R3: `sense_blank` is high, and `sense_hit` has no effect, in on-period cycles with n < BLANK_CYC. A hit at n = 62 leaves `gate` high. A hit held through the whole on-period ends it after exactly 64 cycles.
- R4: `sense_strobe` is a single-cycle pulse in the cycle with n = STROBE_CYC (94). It occurs only while `gate` is high and never inside the blanking window.
- R5: After an on-period ends, `gate` stays low for exactly `toff_cycles` cycles and then rises for a new on-period. The value is captured at the edge where `gate` falls, and later changes do not affect the current off-period. A value of 0 acts as 1.
- R6: Each of the following forces `gate` low at the next clock edge: `chip_en` low, `supply_ok` low, `dim_blank` high or `prot_off` high. When all four are released, a fresh on-period starts at the next edge, with n restarting from 0.
- R7: If no hit is taken for MAXON_CYC (2500) cycles of an on-period, `gate` falls. `max_on_hit` is then high for exactly the first off cycle, and the normal off-time follows.
- R8: After reset, `gate`, `sense_strobe`, `sense_blank` and `max_on_hit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Channel enable |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| dim_blank | input | 1 | Dimming off phase; high forces the gate low |
| prot_off | input | 1 | Gate-off request from the protection logic |
| sense_hit | input | 1 | Current-sense comparator: sensed level at or above the reference |
| toff_cycles | input | TOFF_W | Off-time in clock cycles |
| gate | output | 1 | Gate command |
| sense_strobe | output | 1 | One-cycle sample strobe for the protection logic |
| sense_blank | output | 1 | Blanking window active |
| max_on_hit | output | 1 | One-cycle flag: the on-period was ended by the on-time limit |

## Verification
The hardest situations to reach from the ports are the exact edges of the blanking window and the on-time limit. The comparator is never watched until the window closes, and the limit is reached only after thousands of quiet cycles. The bench aligns itself to each observed gate rise and then counts clock cycles. It pulses the comparator at n = 62 (which must be ignored) and then again past the window, and it holds the comparator low through a full 2500-cycle on-period. Forced-off cases are placed at known counts, including right after a strobe, to show that released channels restart with a fresh window.

// File: rtl/cot_pkg.sv
package cot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;

  // true once an on-period count has left the blanking window
  function automatic logic f_blank_over(input int unsigned n, input int unsigned blank);
    return n >= blank;
  endfunction

  // off-time actually used: zero is promoted to one cycle
  function automatic int unsigned f_off_load(input int unsigned req);
    return (req == 0) ? 1 : req;
  endfunction

endpackage

// File: rtl/cot_run_qual.sv
module cot_run_qual (
  input  logic chip_en,
  input  logic supply_ok,
  input  logic dim_blank,
  input  logic prot_off,
  output logic run
);
  always_comb run = chip_en & supply_ok & ~dim_blank & ~prot_off;
endmodule

// File: rtl/cot_on_timer.sv
module cot_on_timer #(
  parameter int BLANK_CYC  = 63,
  parameter int STROBE_CYC = 94,
  parameter int MAXON_CYC  = 2500,
  localparam int CW = $clog2(MAXON_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  output logic in_blank,
  output logic strobe_at,
  output logic limit_at
);
  localparam logic [CW-1:0] STROBE_V = CW'(STROBE_CYC);
  localparam logic [CW-1:0] LIMIT_V  = CW'(MAXON_CYC - 1);
  localparam logic [CW-1:0] SAT_V    = CW'(MAXON_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (active && cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  always_comb begin
    in_blank  = active && !cot_pkg::f_blank_over(32'(cnt), BLANK_CYC);
    strobe_at = active && (cnt == STROBE_V);
    limit_at  = active && (cnt == LIMIT_V);
  end
endmodule

// File: rtl/cot_off_timer.sv
module cot_off_timer #(
  parameter int TOFF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TOFF_W-1:0] load_val,
  input  logic              active,
  output logic              done
);
  logic [TOFF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= TOFF_W'(cot_pkg::f_off_load(32'(load_val)));
    else if (active && cnt > 'd1)   cnt <= cnt - 1'b1;
  end

  always_comb done = active && (cnt <= 'd1);
endmodule

// File: rtl/cot_gate_seq.sv
module cot_gate_seq #(
  parameter int TOFF_W     = 12,
  parameter int BLANK_CYC  = 63,
  parameter int STROBE_CYC = 94,
  parameter int MAXON_CYC  = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              supply_ok,
  input  logic              dim_blank,
  input  logic              prot_off,
  input  logic              sense_hit,
  input  logic [TOFF_W-1:0] toff_cycles,
  output logic              gate,
  output logic              sense_strobe,
  output logic              sense_blank,
  output logic              max_on_hit
);
  import cot_pkg::*;

  phase_t phase, phase_nx;
  logic run, in_blank, strobe_at, limit_at, off_done;
  logic hit_take, end_on, enter_on, on_act, off_act;

  cot_run_qual u_qual (
    .chip_en(chip_en), .supply_ok(supply_ok),
    .dim_blank(dim_blank), .prot_off(prot_off), .run(run)
  );

  always_comb begin
    on_act   = (phase == PH_ON);
    off_act  = (phase == PH_OFF);
    hit_take = on_act && sense_hit && !in_blank;
    end_on   = on_act && (hit_take || limit_at);
    enter_on = run && ((phase == PH_IDLE) || off_done);
  end

  cot_on_timer #(
    .BLANK_CYC(BLANK_CYC), .STROBE_CYC(STROBE_CYC), .MAXON_CYC(MAXON_CYC)
  ) u_on (
    .clk(clk), .rst_n(rst_n), .clr(enter_on), .active(on_act),
    .in_blank(in_blank), .strobe_at(strobe_at), .limit_at(limit_at)
  );

  cot_off_timer #(.TOFF_W(TOFF_W)) u_off (
    .clk(clk), .rst_n(rst_n), .load(run && end_on), .load_val(toff_cycles),
    .active(off_act), .done(off_done)
  );

  always_comb begin
    phase_nx = phase;
    if (!run) phase_nx = PH_IDLE;
    else begin
      unique case (phase)
        PH_IDLE: phase_nx = PH_ON;
        PH_ON:   if (end_on)   phase_nx = PH_OFF;
        PH_OFF:  if (off_done) phase_nx = PH_ON;
        default: phase_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      max_on_hit <= 1'b0;
    end else begin
      phase      <= phase_nx;
      max_on_hit <= run && limit_at && !hit_take;
    end
  end

  always_comb begin
    gate         = on_act;
    sense_strobe = strobe_at;
    sense_blank  = in_blank;
  end
endmodule

// File: rtl/cot_gate_seq_chk.sv
module cot_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic supply_ok,
  input logic dim_blank,
  input logic prot_off,
  input logic sense_hit,
  input logic gate,
  input logic sense_strobe,
  input logic sense_blank,
  input logic max_on_hit
);
  logic run_ok;
  always_comb run_ok = chip_en && supply_ok && !dim_blank && !prot_off;

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> !gate); // R6
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && sense_blank && run_ok) |=> gate); // R3
  AST_HIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && sense_hit && !sense_blank) |=> !gate); // R2
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |-> (gate && !sense_blank)); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |=> !sense_strobe); // R4
  AST_MAXON_FIRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    max_on_hit |-> (!gate && $past(gate))); // R7
  AST_MAXON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    max_on_hit |=> !max_on_hit); // R7
  AST_RISE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> sense_blank); // R3
endmodule

bind cot_gate_seq cot_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .supply_ok(supply_ok),
  .dim_blank(dim_blank), .prot_off(prot_off), .sense_hit(sense_hit),
  .gate(gate), .sense_strobe(sense_strobe), .sense_blank(sense_blank),
  .max_on_hit(max_on_hit)
);

// File: tb/sim_cot_gate_seq.sv
module sim_cot_gate_seq;
  localparam int TW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_en = 0, supply_ok = 0, dim_blank = 0, prot_off = 0, sense_hit = 0;
  logic [TW-1:0] toff_cycles = '0;
  logic gate, sense_strobe, sense_blank, max_on_hit;

  always #4 clk = ~clk;

  cot_gate_seq #(.TOFF_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .supply_ok(supply_ok),
    .dim_blank(dim_blank), .prot_off(prot_off), .sense_hit(sense_hit),
    .toff_cycles(toff_cycles), .gate(gate), .sense_strobe(sense_strobe),
    .sense_blank(sense_blank), .max_on_hit(max_on_hit)
  );

  typedef enum int {EV_RISE, EV_FALL, EV_STROBE, EV_MAXON} ev_t;
  typedef struct { ev_t kind; int delta; string req; } exp_t;
  exp_t expq[$];

  int checks = 0, failures = 0, cyc = 0, last_cyc = 0;
  logic gate_prev = 1'b0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input ev_t k, input int d, input string req);
    exp_t e;
    e.kind = k; e.delta = d; e.req = req;
    expq.push_back(e);
  endtask

  task automatic seen(input ev_t k);
    exp_t e;
    int d;
    d = cyc - last_cyc;
    last_cyc = cyc;
    if (expq.size() == 0) begin
      chk(0, "R0", "unexpected event kind", int'(k), -1);
      return;
    end
    e = expq.pop_front();
    chk(e.kind == k, e.req, "event kind", int'(k), int'(e.kind));
    if (e.delta >= 0) chk(d == e.delta, e.req, "cycles since previous event", d, e.delta);
  endtask

  // monitor: events in fixed order within one sample point
  always @(negedge clk) begin
    if (rst_n) begin
      if (gate && !gate_prev) seen(EV_RISE);
      if (!gate && gate_prev) seen(EV_FALL);
      if (sense_strobe) seen(EV_STROBE);
      if (max_on_hit) seen(EV_MAXON);
      gate_prev = gate;
    end
  end

  task automatic drain();
    wait (expq.size() == 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R0", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(gate == 0, "R8", "gate in reset", gate, 0);
    chk(sense_strobe == 0 && sense_blank == 0 && max_on_hit == 0, "R8",
        "strobe/blank/flag in reset", {sense_strobe, sense_blank, max_on_hit}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(gate == 0, "R8", "gate after reset release, disabled", gate, 0);

    // S1: normal cycles, held hit inside blanking, off-time capture
    toff_cycles = 100;
    push(EV_RISE, -1, "R1");
    push(EV_STROBE, 94, "R4");
    chip_en = 1; supply_ok = 1;
    @(negedge clk);
    chk(gate == 1, "R1", "gate one edge after enable", gate, 1);
    chk(sense_blank == 1, "R3", "blank at start of on-period", sense_blank, 1);
    drain();
    repeat (105) @(negedge clk);
    sense_hit = 1;
    push(EV_FALL, 106, "R2");
    push(EV_RISE, 100, "R5");
    push(EV_FALL, 64, "R3");
    push(EV_RISE, 20, "R5");
    push(EV_FALL, 64, "R3");
    wait (expq.size() == 4);
    toff_cycles = 20;  // does not touch the off-period in progress
    drain();
    chip_en = 0; sense_hit = 0;
    repeat (30) @(negedge clk);
    chk(gate == 0, "R6", "gate stays low while disabled", gate, 0);

    // S2: forced-off sources and fresh restart
    toff_cycles = 50;
    push(EV_RISE, -1, "R1");
    chip_en = 1;
    drain();
    repeat (10) @(negedge clk);
    dim_blank = 1;
    push(EV_FALL, 11, "R6");
    @(negedge clk);
    chk(gate == 0, "R6", "dimming forces gate low", gate, 0);
    push(EV_RISE, 1, "R6");
    push(EV_STROBE, 94, "R4");
    dim_blank = 0;
    drain();
    prot_off = 1;
    push(EV_FALL, 1, "R6");
    @(negedge clk);
    chk(gate == 0, "R6", "protection forces gate low", gate, 0);
    chk(sense_strobe == 0, "R4", "no strobe after forced off", sense_strobe, 0);
    push(EV_RISE, 1, "R6");
    prot_off = 0;
    drain();
    chk(sense_blank == 1, "R6", "restart opens a fresh blanking window", sense_blank, 1);
    supply_ok = 0;
    push(EV_FALL, 1, "R6");
    @(negedge clk);
    chk(gate == 0, "R6", "supply loss forces gate low", gate, 0);
    push(EV_RISE, 1, "R6");
    supply_ok = 1;
    drain();
    chip_en = 0;
    push(EV_FALL, 1, "R6");
    @(negedge clk);
    chk(gate == 0, "R6", "enable low forces gate low", gate, 0);
    drain();
    repeat (5) @(negedge clk);

    // S3: maximum on-time
    toff_cycles = 30;
    push(EV_RISE, -1, "R1");
    push(EV_STROBE, 94, "R4");
    push(EV_FALL, 2406, "R7");
    push(EV_MAXON, 0, "R7");
    push(EV_RISE, 30, "R7");
    chip_en = 1;
    wait (expq.size() == 1);
    @(negedge clk);
    chk(max_on_hit == 0, "R7", "limit flag lasts one cycle", max_on_hit, 0);
    drain();
    chip_en = 0;
    push(EV_FALL, 1, "R6");
    drain();
    repeat (5) @(negedge clk);

    // S4: zero off-time acts as one, hit held from the start
    toff_cycles = 0;
    sense_hit = 1;
    push(EV_RISE, -1, "R1");
    push(EV_FALL, 64, "R3");
    push(EV_RISE, 1, "R5");
    push(EV_FALL, 64, "R3");
    chip_en = 1;
    drain();
    chip_en = 0; sense_hit = 0;
    repeat (5) @(negedge clk);

    // S5: blanking boundary
    toff_cycles = 10;
    push(EV_RISE, -1, "R1");
    chip_en = 1;
    drain();
    repeat (62) @(negedge clk);
    chk(sense_blank == 1, "R3", "blank at n=62", sense_blank, 1);
    sense_hit = 1;
    @(negedge clk);
    sense_hit = 0;
    chk(gate == 1, "R3", "hit at n=62 ignored", gate, 1);
    chk(sense_blank == 0, "R3", "blank closed at n=63", sense_blank, 0);
    repeat (7) @(negedge clk);
    sense_hit = 1;
    push(EV_FALL, 71, "R2");
    push(EV_RISE, 10, "R5");
    wait (expq.size() == 1);
    sense_hit = 0;
    drain();
    chip_en = 0;
    push(EV_FALL, 1, "R6");
    drain();
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R0", "expected events left over", expq.size(), 0);
    summary();
  end
endmodule